// File: doc/BRIEF.md
# Frame-Synchronous Control Register Bank

This block holds the configuration of an imaging timing generator and is loaded over a three-pin serial port: a data line, a bit clock and a load strobe. A configuration write lands first in a shadow copy. The shadow copy reaches the active copy that drives the timing logic only on a frame or line sync event, and only while an update-hold flag is clear. Software can therefore change several settings at once and have them all take effect together at a frame boundary.

Three controls act at once and skip the shadow stage. The first is a self-clearing software reset. The second is an active-low run control for the timing core, which starts only after a 0 and then a 1 have been written. The third is the update-hold flag itself. A fourth control, the output enable, is deferred like the configuration words. While it is inactive, every clock output is held low.

All serial and sync pins are asynchronous to the master clock. Each pin passes through a two-flop synchronizer before any edge is detected.

Top module: `frame_sync_regbank`

## Requirements
- R1: While `por_n` is low, and after it is released with no serial write, every active configuration word equals `CFG_DEFAULT`, and `out_en`, `core_run` and all bits of `tclk_out` are 0.
- R2: A serial frame is an 8-bit address followed by a `DW`-bit data word, both least significant bit first. Each bit is sampled on a rising edge of `sclk`, and the write commits on a rising edge of `sload`. Each pin is synchronized by two master-clock flops, so a pin edge is acted on at the third master-clock edge after the pin changes.
- R3: A write to address `i` (0 ≤ i < `NREG`) updates only the shadow word `i`. Active words change only on a transfer or a reset, and a transfer copies every shadow word to `cfg_active[i*DW +: DW]`.
- R4: A transfer happens on a synchronized falling edge of `vd`, or on a synchronized falling edge of `hd` while the synchronized `vd` is low. A falling edge of `hd` while `vd` is high causes no transfer.
- R5: Address 0x14, data bit 0, is the update-hold flag and takes effect at once. While it is 1, sync edges transfer nothing. After it is cleared, the next sync edge transfers all pending shadow values.
- R6: Address 0x11, data bit 0, is the output enable. It is deferred like the configuration words and drives `out_en` after a transfer. `tclk_out` equals `tclk_in` while `out_en` is 1 and is all zeros otherwise.
- R7: Address 0x12, data bit 0, is the active-low core reset and takes effect at once. Writing 0 clears `core_run`. Writing 1 sets `core_run` only if a 0 has been written since the last reset.
- R8: Address 0x10 with data bit 0 set returns the shadow words, active words, output enable, update-hold flag and core state to their defaults in one cycle. The bit does not stay set. With data bit 0 clear, the write has no effect.
- R9: A write to any address outside 0..`NREG`-1, 0x10, 0x11, 0x12 and 0x14 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sclk | input | 1 | Serial bit clock |
| sdata | input | 1 | Serial data, least significant bit first |
| sload | input | 1 | Serial load strobe; rising edge commits the frame |
| vd | input | 1 | Frame sync input |
| hd | input | 1 | Line sync input |
| tclk_in | input | NCLK | Timing clocks from the waveform generator |
| cfg_active | output | NREG*DW | Active configuration words, word i at bits i*DW +: DW |
| out_en | output | 1 | Applied output enable |
| core_run | output | 1 | Timing core run indication |
| tclk_out | output | NCLK | Gated timing clocks |

## Verification
On every cycle, the assertions check four things: active words move only on a transfer that is not held or on a software reset, a held bank keeps its active state frozen, the core starts only on a write of 1 to its control, and an unmapped write leaves all state untouched. The software reset landing on defaults is also checked each cycle. The exact cycle at which a serial frame or a sync edge takes effect, and the separation of line edges inside and outside the frame blanking, can only be shown by the bench. The bench compares the outputs of its behavioural model on every clock. The order in which hold, enable and transfer interact is also shown only by the bench scenarios.

// File: rtl/frame_sync_regbank.sv
module frame_sync_regbank #(
  parameter int DW = 8,
  parameter int NREG = 8,
  parameter int NCLK = 4,
  parameter logic [DW-1:0] CFG_DEFAULT = '0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              sload,
  input  logic              vd,
  input  logic              hd,
  input  logic [NCLK-1:0]   tclk_in,
  output logic [NREG*DW-1:0] cfg_active,
  output logic              out_en,
  output logic              core_run,
  output logic [NCLK-1:0]   tclk_out
);
  localparam int FW = 8 + DW;
  localparam logic [7:0] A_SWRST = 8'h10;
  localparam logic [7:0] A_OE    = 8'h11;
  localparam logic [7:0] A_CORE  = 8'h12;
  localparam logic [7:0] A_HOLD  = 8'h14;

  logic [2:0] sclk_q, sload_q, vd_q, hd_q;
  logic [1:0] sdata_q;
  logic [FW-1:0] sr;
  logic [NREG-1:0][DW-1:0] sh, act;
  logic oe_sh, hold, armed;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      sclk_q <= '0; sload_q <= '0; vd_q <= '0; hd_q <= '0; sdata_q <= '0;
    end else begin
      sclk_q  <= {sclk_q[1:0], sclk};
      sload_q <= {sload_q[1:0], sload};
      vd_q    <= {vd_q[1:0], vd};
      hd_q    <= {hd_q[1:0], hd};
      sdata_q <= {sdata_q[0], sdata};
    end

  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire commit    = sload_q[1] & ~sload_q[2];
  wire vd_fall   = vd_q[2] & ~vd_q[1];
  wire hd_fall   = hd_q[2] & ~hd_q[1];
  wire strobe    = vd_fall | (hd_fall & ~vd_q[1]);
  wire xfer      = strobe & ~hold;

  wire [7:0]    wa = sr[7:0];
  wire [DW-1:0] wd = sr[FW-1:8];
  wire cfg_hit   = commit && (int'(wa) < NREG);
  wire swrst_hit = commit && wa == A_SWRST && wd[0];
  wire core_wr1  = commit && wa == A_CORE && wd[0];
  wire unmapped  = commit && !(int'(wa) < NREG) && wa != A_SWRST && wa != A_OE
                   && wa != A_CORE && wa != A_HOLD;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) sr <= '0;
    else if (sclk_rise) sr <= {sdata_q[1], sr[FW-1:1]};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      sh <= {NREG{CFG_DEFAULT}}; act <= {NREG{CFG_DEFAULT}};
      oe_sh <= 1'b0; out_en <= 1'b0; hold <= 1'b0; armed <= 1'b0; core_run <= 1'b0;
    end else if (swrst_hit) begin
      sh <= {NREG{CFG_DEFAULT}}; act <= {NREG{CFG_DEFAULT}};
      oe_sh <= 1'b0; out_en <= 1'b0; hold <= 1'b0; armed <= 1'b0; core_run <= 1'b0;
    end else begin
      if (xfer) begin
        act    <= sh;
        out_en <= oe_sh;
      end
      if (cfg_hit) sh[wa[$clog2(NREG+1)-1:0]] <= wd;
      if (commit && wa == A_OE) oe_sh <= wd[0];
      if (commit && wa == A_HOLD) hold <= wd[0];
      if (commit && wa == A_CORE) begin
        if (wd[0]) core_run <= armed;
        else begin
          core_run <= 1'b0;
          armed    <= 1'b1;
        end
      end
    end

  assign cfg_active = act;
  assign tclk_out   = out_en ? tclk_in : '0;

  assert_only_at_sync_R3: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(act) |-> $past(xfer) || $past(swrst_hit));
  assert_hold_freezes_R5: assert property (@(posedge clk) disable iff (!por_n)
    ($past(hold) && !$past(swrst_hit)) |-> ($stable(act) && $stable(out_en)));
  assert_core_start_R7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_run) |-> $past(core_wr1));
  assert_swrst_defaults_R8: assert property (@(posedge clk) disable iff (!por_n)
    $past(swrst_hit) |-> (act == {NREG{CFG_DEFAULT}} && !out_en && !core_run && !hold && !oe_sh));
  assert_unmapped_ignored_R9: assert property (@(posedge clk) disable iff (!por_n)
    $past(unmapped) |-> ($stable(sh) && $stable(oe_sh) && $stable(hold) && $stable(core_run)));
endmodule

// File: tb/frame_sync_regbank_tb.sv
`timescale 1ns/1ps
module frame_sync_regbank_tb;
  localparam int DW = 8, NREG = 8, NCLK = 4, FW = 8 + DW;

  logic clk = 0, por_n = 0, sclk = 0, sdata = 0, sload = 0, vd = 0, hd = 0;
  logic [NCLK-1:0] tclk_in = '0;
  logic [NREG*DW-1:0] cfg_active;
  logic out_en, core_run;
  logic [NCLK-1:0] tclk_out;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  frame_sync_regbank #(.DW(DW), .NREG(NREG), .NCLK(NCLK)) u_dut (
    .clk(clk), .por_n(por_n), .sclk(sclk), .sdata(sdata), .sload(sload),
    .vd(vd), .hd(hd), .tclk_in(tclk_in), .cfg_active(cfg_active),
    .out_en(out_en), .core_run(core_run), .tclk_out(tclk_out));

  // behavioural reference model
  int m_sh[NREG], m_act[NREG];
  int m_oe_sh, m_oe, m_hold, m_run, m_armed;
  bit bits[$];
  int h_sclk[3], h_sload[3], h_vd[3], h_hd[3], h_sd[3];

  task automatic m_reset(bit full);
    for (int i = 0; i < NREG; i++) begin m_sh[i] = 0; m_act[i] = 0; end
    m_oe_sh = 0; m_oe = 0; m_hold = 0; m_run = 0; m_armed = 0;
    if (full) begin
      bits.delete();
      for (int i = 0; i < FW; i++) bits.push_back(1'b0);
      for (int i = 0; i < 3; i++) begin
        h_sclk[i] = 0; h_sload[i] = 0; h_vd[i] = 0; h_hd[i] = 0; h_sd[i] = 0;
      end
    end
  endtask

  always @(posedge clk or negedge por_n) begin
    if (!por_n) m_reset(1);
    else begin
      bit srise, lrise, strobe;
      int a, d;
      srise  = h_sclk[1] && !h_sclk[2];
      lrise  = h_sload[1] && !h_sload[2];
      strobe = (h_vd[2] && !h_vd[1]) || (h_hd[2] && !h_hd[1] && !h_vd[1]);
      a = 0; d = 0;
      for (int i = 0; i < 8; i++) a += bits[i] << i;
      for (int i = 0; i < DW; i++) d += bits[8+i] << i;
      if (lrise && a == 'h10 && d[0]) m_reset(0);
      else begin
        if (strobe && !m_hold) begin
          for (int i = 0; i < NREG; i++) m_act[i] = m_sh[i];
          m_oe = m_oe_sh;
        end
        if (lrise) begin
          if (a < NREG) m_sh[a] = d;
          else if (a == 'h11) m_oe_sh = d[0];
          else if (a == 'h14) m_hold = d[0];
          else if (a == 'h12) begin
            if (d[0]) m_run = m_armed;
            else begin m_run = 0; m_armed = 1; end
          end
        end
      end
      if (srise) begin bits.push_back(h_sd[1][0]); void'(bits.pop_front()); end
      for (int i = 2; i > 0; i--) begin
        h_sclk[i] = h_sclk[i-1]; h_sload[i] = h_sload[i-1];
        h_vd[i] = h_vd[i-1]; h_hd[i] = h_hd[i-1]; h_sd[i] = h_sd[i-1];
      end
      h_sclk[0] = sclk; h_sload[0] = sload; h_vd[0] = vd; h_hd[0] = hd; h_sd[0] = sdata;
    end
  end

  task automatic check(string req, logic [NREG*DW-1:0] act, logic [NREG*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!done) begin
      logic [NREG*DW-1:0] mc;
      for (int i = 0; i < NREG; i++) mc[i*DW +: DW] = DW'(m_act[i]);
      check("R3 cycle cfg_active", cfg_active, mc);
      check("R6 cycle out_en", NREG*DW'(out_en), NREG*DW'(m_oe));
      check("R7 cycle core_run", NREG*DW'(core_run), NREG*DW'(m_run));
      check("R6 cycle tclk_out", NREG*DW'(tclk_out), NREG*DW'(m_oe ? tclk_in : '0));
    end
  end

  always @(negedge clk) tclk_in <= tclk_in + 1'b1;

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ser_write(logic [7:0] addr, logic [DW-1:0] data);
    for (int i = 0; i < FW; i++) begin
      @(negedge clk);
      sdata = (i < 8) ? addr[i] : data[i-8];
      sclk = 0;
      wait_n(3); sclk = 1;
      wait_n(3); sclk = 0;
    end
    wait_n(2); sload = 1;
    wait_n(4); sload = 0;
    wait_n(4);
  endtask

  task automatic vd_pulse();
    @(negedge clk); vd = 1; wait_n(5); vd = 0; wait_n(6);
  endtask

  task automatic hd_pulse();
    @(negedge clk); hd = 1; wait_n(5); hd = 0; wait_n(6);
  endtask

  function automatic logic [NREG*DW-1:0] word(int idx, logic [DW-1:0] v,
                                              logic [NREG*DW-1:0] base);
    logic [NREG*DW-1:0] r = base;
    r[idx*DW +: DW] = v;
    return r;
  endfunction

  initial begin
    logic [NREG*DW-1:0] exp;
    #(200000 * 5);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NREG*DW-1:0] exp;
    exp = '0;
    wait_n(5); por_n = 1; wait_n(3);
    check("R1 reset cfg", cfg_active, '0);
    check("R1 reset flags", {out_en, core_run, tclk_out}, '0);

    ser_write(8'h02, 8'hA5); ser_write(8'h07, 8'h3C);
    check("R3 shadow only before sync", cfg_active, '0);
    vd_pulse();
    exp = word(7, 8'h3C, word(2, 8'hA5, exp));
    check("R3 transfer at vd fall", cfg_active, exp);

    ser_write(8'h05, 8'h01); ser_write(8'h06, 8'h80); vd_pulse();
    exp = word(6, 8'h80, word(5, 8'h01, exp));
    check("R2 lsb-first framing", cfg_active, exp);

    ser_write(8'h00, 8'h11); hd_pulse();
    exp = word(0, 8'h11, exp);
    check("R4 hd fall with vd low", cfg_active, exp);
    ser_write(8'h01, 8'h22);
    @(negedge clk); vd = 1; wait_n(4); hd_pulse();
    check("R4 hd fall with vd high ignored", cfg_active, exp);
    vd = 0; wait_n(6);
    exp = word(1, 8'h22, exp);
    check("R4 vd fall transfers", cfg_active, exp);

    ser_write(8'h14, 8'h01); ser_write(8'h03, 8'h77); vd_pulse();
    check("R5 hold blocks transfer", cfg_active, exp);
    ser_write(8'h14, 8'h00);
    check("R5 clear alone no transfer", cfg_active, exp);
    vd_pulse();
    exp = word(3, 8'h77, exp);
    check("R5 pending applied after clear", cfg_active, exp);

    ser_write(8'h11, 8'h01);
    check("R6 enable deferred", {out_en, tclk_out}, '0);
    vd_pulse();
    check("R6 enable applied", out_en, 1'b1);
    check("R6 clocks pass", tclk_out, tclk_in);

    ser_write(8'h12, 8'h01);
    check("R7 one without zero", core_run, 1'b0);
    ser_write(8'h12, 8'h00);
    check("R7 zero written", core_run, 1'b0);
    ser_write(8'h12, 8'h01);
    check("R7 zero then one runs", core_run, 1'b1);

    ser_write(8'h20, 8'hFF); ser_write(8'h13, 8'hFF); ser_write(8'hFF, 8'hFF);
    vd_pulse();
    check("R9 unmapped ignored", cfg_active, exp);
    check("R9 unmapped flags", {out_en, core_run}, 2'b11);

    ser_write(8'h10, 8'h00);
    check("R8 swrst bit clear no effect", {out_en, core_run}, 2'b11);
    ser_write(8'h14, 8'h01);
    ser_write(8'h10, 8'h01);
    check("R8 swrst cfg default", cfg_active, '0);
    check("R8 swrst flags default", {out_en, core_run, tclk_out}, '0);
    ser_write(8'h04, 8'h5A); vd_pulse();
    check("R8 hold cleared by swrst", cfg_active, word(4, 8'h5A, '0));
    check("R8 enable shadow cleared", out_en, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule